// File: doc/BRIEF.md
# Register-Mapped Serial Flash Controller

This block is a half-duplex SPI master for a serial flash device. A CPU drives it through a small 32-bit register bus with three registers: byte-order configuration, control/status, and a data window. Each data-register access moves one to four bytes. The byte count comes from a two-bit length field. Writing the data window sends bytes on MOSI. Reading the data window returns the word captured by the previous receive and starts a new receive from MISO.

Software drives the chip-select pins directly through two active-low control bits. It polls a ready flag before each data access. The serial clock runs in mode 0: it idles low, MOSI changes after a falling edge, and MISO is sampled on a rising edge. Each half period of the serial clock lasts a fixed number of system clocks, set by a parameter. Two order bits decide whether multi-byte words go on the wire starting from the top byte lane or the bottom one.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset, both chip-select pins are high and the configuration register reads 0. The control/status register reads 32'hC800_0000: release bits 31 and 30 set, ready bit 27 set, length code 0, select bit 24 clear.
- R2: The register offsets are 0x00 (configuration), 0x08 (control/status) and 0x0C (data). In the configuration register only bit 28 (receive order) and bit 27 (transmit order) are kept; every other bit reads 0.
- R3: The cycle after a control/status write, pin cs_n[0] equals written bit 31 and pin cs_n[1] equals written bit 30. Bit 24 is stored and reads back.
- R4: Control/status bits 29:28 hold a length code, and each data access moves code+1 bytes. Code 0 moves 1 byte and code 3 moves 4 bytes, so the serial clock gives 8×(code+1) rising edges.
- R5: A data write while ready is 1 clears ready (status bit 27) by the next cycle. Ready returns to 1 after the last falling edge of the serial clock.
- R6: Transmit bytes go out MSB-first. A 1-byte transfer sends bits 31:24. A multi-byte transfer sends lanes downward from 31:24 when transmit order is set, and upward from 7:0 when it is clear.
- R7: A data read while ready is 1 returns the word captured by the previous receive and starts a receive of the programmed length. MOSI stays 0 during a receive.
- R8: In a received word, the first byte lands in bits 31:24 for a 1-byte transfer or when receive order is set. When receive order is clear and the transfer is multi-byte, bytes fill lanes upward from 7:0. Lanes that receive no byte read 0.
- R9: A data write or data read while ready is 0 has no effect: the bytes on the wire do not change and no new transfer starts.
- R10: The serial clock idles low, and each half period lasts HALF_DIV system clocks. MOSI never changes while the serial clock is high.
- R11: Status bit 27 is read-only: writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The bench builds the block with HALF_DIV = 3 rather than the default 2, so each half period spans several divider counts. This checks that the divider terminal count, rather than a fixed toggle, sets the serial-clock width; the bench counts high-phase cycles to confirm it. Random stimulus uses all four length codes with both order bits. The bench therefore covers the 2- and 3-byte lane placements and the byte swap for each order setting.

// File: rtl/sfc_pkg.sv
// Shared constants and helpers for the serial flash controller.
// Assumes a 32-bit data word and byte-addressed register offsets.
package sfc_pkg;
    localparam int ADDR_W = 4;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int BITS_W = $clog2(WORD_W) + 1;

    localparam logic [ADDR_W-1:0] OFS_CFG = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTL = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_DAT = 4'hC;

    localparam int B_RX_ORDER = 28;
    localparam int B_TX_ORDER = 27;
    localparam int B_REL0     = 31;
    localparam int B_REL1     = 30;
    localparam int B_LEN      = 28;
    localparam int B_READY    = 27;
    localparam int B_PICK     = 24;

    typedef struct packed {
        logic rx_msb_first;
        logic tx_msb_first;
    } order_t;
endpackage

// File: rtl/sfc_lane_order.sv
// Byte-lane arrangement between the bus word and the serial bit stream.
// Assumes the shifter sends from bit WORD_W-1 downward and collects
// received bits right-aligned, with the earliest bit highest.
module sfc_lane_order
    import sfc_pkg::*;
(
    input  logic [1:0]        tx_len,
    input  logic [1:0]        rx_len,
    input  order_t            order,
    input  logic [WORD_W-1:0] tx_raw,
    input  logic [WORD_W-1:0] rx_raw,
    output logic [WORD_W-1:0] tx_load,
    output logic [WORD_W-1:0] rx_word,
    output logic [BITS_W-1:0] tx_nbits
);
    logic [WORD_W-1:0] tx_swap, rx_left, rx_swap;
    logic [2:0]        rx_bytes;

    // Reverse byte lanes for the ascending-order variants.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tx_swap[g*8 +: 8] = tx_raw[(LANES-1-g)*8 +: 8];
        assign rx_swap[g*8 +: 8] = rx_left[(LANES-1-g)*8 +: 8];
    end

    // Choose the transmit word and the bit count for the shifter.
    always_comb begin
        tx_load  = (tx_len != 2'd0 && !order.tx_msb_first) ? tx_swap : tx_raw;
        tx_nbits = BITS_W'((32'(tx_len) + 1) * 8);
    end

    // Left-align the received bytes, then reorder them if needed.
    always_comb begin
        rx_bytes = {1'b0, rx_len} + 3'd1;
        rx_left  = rx_raw << ((3'd4 - rx_bytes) * 8);
        rx_word  = (rx_len != 2'd0 && !order.rx_msb_first) ? rx_swap : rx_left;
    end
endmodule

// File: rtl/sfc_shifter.sv
// Mode-0 serial engine: SCK idles low, MOSI changes after a falling edge,
// MISO is sampled on a rising edge. Each half period is HALF_DIV clocks.
// Assumes start is only raised while busy is low.
module sfc_shifter
    import sfc_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tx_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic [BITS_W-1:0] nbits,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_bits
);
    localparam int DCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DCW-1:0]    div_q;
    logic [BITS_W-1:0] bit_q, last_q;
    logic [WORD_W-1:0] tx_q, rx_q;
    logic              sck_q, busy_q, done_q;
    logic              half_end;

    assign half_end = (div_q == DCW'(HALF_DIV - 1));

    // Sequence the bit phases, shift data and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            last_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    tx_q   <= tx_en ? load_word : '0;
                    rx_q   <= '0;
                    bit_q  <= '0;
                    last_q <= nbits - 1'b1;
                    div_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (half_end) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[WORD_W-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
                    if (bit_q == last_q) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = busy_q & tx_q[WORD_W-1];
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_bits = rx_q;
endmodule

// File: rtl/sfc_regs.sv
// Register file and access decode. Data accesses start a transfer only
// while the shifter is idle; all other data accesses are dropped.
// Assumes single-cycle bus strobes and combinational read data.
module sfc_regs
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] rx_word,
    output order_t            order,
    output logic [1:0]        cs_rel,
    output logic [1:0]        len_code,
    output logic [1:0]        len_active,
    output logic              start,
    output logic              start_tx
);
    logic       pick_q, rx_op_q;
    logic [WORD_W-1:0] cap_q;
    logic       hit_cfg, hit_ctl, hit_dat, dat_access;

    assign hit_cfg    = bus_valid && bus_addr == OFS_CFG;
    assign hit_ctl    = bus_valid && bus_addr == OFS_CTL;
    assign hit_dat    = bus_valid && bus_addr == OFS_DAT;
    assign dat_access = hit_dat && !busy;
    assign start      = dat_access;
    assign start_tx   = dat_access && bus_write;

    // Hold configuration and control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order    <= '0;
            cs_rel   <= 2'b11;
            len_code <= 2'd0;
            pick_q   <= 1'b0;
        end else begin
            if (hit_cfg && bus_write) begin
                order.rx_msb_first <= bus_wdata[B_RX_ORDER];
                order.tx_msb_first <= bus_wdata[B_TX_ORDER];
            end
            if (hit_ctl && bus_write) begin
                cs_rel[0] <= bus_wdata[B_REL0];
                cs_rel[1] <= bus_wdata[B_REL1];
                len_code  <= bus_wdata[B_LEN +: 2];
                pick_q    <= bus_wdata[B_PICK];
            end
        end
    end

    // Latch the length and direction of the running transfer, and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_active <= 2'd0;
            rx_op_q    <= 1'b0;
            cap_q      <= '0;
        end else begin
            if (start) begin
                len_active <= len_code;
                rx_op_q    <= !bus_write;
            end
            if (xfer_done && rx_op_q) cap_q <= rx_word;
        end
    end

    // Return the selected register view.
    always_comb begin
        bus_rdata = '0;
        if (hit_cfg) begin
            bus_rdata[B_RX_ORDER] = order.rx_msb_first;
            bus_rdata[B_TX_ORDER] = order.tx_msb_first;
        end else if (hit_ctl) begin
            bus_rdata[B_REL0]     = cs_rel[0];
            bus_rdata[B_REL1]     = cs_rel[1];
            bus_rdata[B_LEN +: 2] = len_code;
            bus_rdata[B_READY]    = !busy;
            bus_rdata[B_PICK]     = pick_q;
        end else if (hit_dat) begin
            bus_rdata = cap_q;
        end
    end
endmodule

// File: rtl/spi_flash_ctrl.sv
// Top level of the half-duplex serial flash controller: register file,
// lane arrangement and mode-0 shifter. Chip selects follow software.
module spi_flash_ctrl
    import sfc_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [1:0]        cs_n
);
    order_t            order_w;
    logic [1:0]        cs_rel_w, len_w, len_act_w;
    logic              start_w, start_tx_w, busy_w, done_w;
    logic [WORD_W-1:0] tx_load_w, rx_bits_w, rx_word_w;
    logic [BITS_W-1:0] nbits_w;

    sfc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy_w),
        .xfer_done  (done_w),
        .rx_word    (rx_word_w),
        .order      (order_w),
        .cs_rel     (cs_rel_w),
        .len_code   (len_w),
        .len_active (len_act_w),
        .start      (start_w),
        .start_tx   (start_tx_w)
    );

    sfc_lane_order u_lanes (
        .tx_len   (len_w),
        .rx_len   (len_act_w),
        .order    (order_w),
        .tx_raw   (bus_wdata),
        .rx_raw   (rx_bits_w),
        .tx_load  (tx_load_w),
        .rx_word  (rx_word_w),
        .tx_nbits (nbits_w)
    );

    sfc_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .tx_en     (start_tx_w),
        .load_word (tx_load_w),
        .nbits     (nbits_w),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .busy      (busy_w),
        .done      (done_w),
        .rx_bits   (rx_bits_w)
    );

    assign cs_n = cs_rel_w;
endmodule

// File: rtl/sfc_checker.sv
// Protocol checks for spi_flash_ctrl, attached by bind.
module sfc_checker
    import sfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              sck,
    input logic              mosi,
    input logic [1:0]        cs_n,
    input logic              busy
);
    assert_cs_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_CTL) |=>
        (cs_n == {$past(bus_wdata[B_REL1]), $past(bus_wdata[B_REL0])}));

    assert_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr == OFS_DAT && !busy) |=> busy);

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    assert_idle_mosi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);
endmodule

bind spi_flash_ctrl sfc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .busy      (busy_w)
);

// File: tb/tb_spi_flash_ctrl.sv
module tb_spi_flash_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso;
    logic [1:0]  cs_n;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // Slave model state.
    logic [31:0] slv_word = 32'h0;
    int          slv_idx = 0;
    logic [31:0] mosi_cap = 32'h0;
    int          rises = 0;
    int          hi_cyc = 0;
    bit          mosi_bad = 0;
    bit          mosi_seen = 0;
    logic        prev_sck = 1'b0;
    logic        prev_mosi = 1'b0;
    logic [31:0] prev_cap = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_ctrl #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    assign miso = (slv_idx < 32) ? slv_word[31 - slv_idx] : 1'b0;

    always @(posedge sck) begin
        mosi_cap = {mosi_cap[30:0], mosi};
        rises    = rises + 1;
    end

    always @(negedge sck) slv_idx = slv_idx + 1;

    always @(negedge clk) begin
        if (sck) hi_cyc = hi_cyc + 1;
        if (sck && prev_sck && mosi !== prev_mosi) mosi_bad = 1;
        if (mosi) mosi_seen = 1;
        prev_sck  = sck;
        prev_mosi = mosi;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        v = 32'h0;
        while (!v[27]) bus_rd(4'h8, v);
    endtask

    task automatic clear_mon();
        mosi_cap = 0; rises = 0; hi_cyc = 0; mosi_bad = 0; mosi_seen = 0;
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] exp_tx(input logic [31:0] w, input int n, input bit be);
        logic [31:0] s;
        s = (n > 1 && !be) ? bswap(w) : w;
        return s >> (32 - 8*n);
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] slv, input int n, input bit be);
        logic [31:0] left;
        left = (slv >> (32 - 8*n)) << (32 - 8*n);
        return (n > 1 && !be) ? bswap(left) : left;
    endfunction

    function automatic logic [31:0] low_bits(input logic [31:0] v, input int n);
        return (n == 4) ? v : (v & ((32'h1 << (8*n)) - 1));
    endfunction

    task automatic setup(input int code, input bit rx_be, input bit tx_be);
        bus_wr(4'h0, {3'b0, rx_be, tx_be, 27'h0});
        bus_wr(4'h8, 32'h4000_0000 | (32'(code) << 28));
    endtask

    task automatic do_tx(input logic [31:0] w, input int code, input bit be);
        logic [31:0] v;
        int n;
        n = code + 1;
        setup(code, 1'b0, be);
        clear_mon();
        bus_wr(4'hC, w);
        bus_rd(4'h8, v);
        check(v[27] == 1'b0, "R5 ready low after data write", v, 32'h0);
        wait_ready();
        check(rises == 8*n, "R4 rising edge count", rises, 8*n);
        check(low_bits(mosi_cap, n) == exp_tx(w, n, be), "R6 transmit order", low_bits(mosi_cap, n), exp_tx(w, n, be));
        check(hi_cyc == HALF*8*n && !mosi_bad, "R10 clock high time and MOSI hold", hi_cyc, HALF*8*n);
    endtask

    task automatic do_rx(input logic [31:0] slv, input int code, input bit be);
        logic [31:0] v;
        int n;
        n = code + 1;
        setup(code, be, 1'b0);
        clear_mon();
        slv_word = slv; slv_idx = 0;
        bus_rd(4'hC, v);
        check(v == prev_cap, "R7 R8 read returns previous capture", v, prev_cap);
        wait_ready();
        check(rises == 8*n, "R4 receive edge count", rises, 8*n);
        check(!mosi_seen, "R7 MOSI quiet during receive", 32'(mosi_seen), 32'h0);
        prev_cap = exp_rx(slv, n, be);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check(cs_n == 2'b11, "R1 chip selects after reset", 32'(cs_n), 32'h3);
        bus_rd(4'h8, v);
        check(v == 32'hC800_0000, "R1 control reset value", v, 32'hC800_0000);
        bus_rd(4'h0, v);
        check(v == 32'h0, "R1 config reset value", v, 32'h0);

        // R2 config bits kept
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, v);
        check(v == 32'h1800_0000, "R2 config readback", v, 32'h1800_0000);

        // R3 chip selects, R11 ready read-only
        bus_wr(4'h8, 32'h4000_0000);
        check(cs_n == 2'b10, "R3 select pin 0 active", 32'(cs_n), 32'h2);
        bus_wr(4'h8, 32'h8100_0000);
        check(cs_n == 2'b01, "R3 select pin 1 active", 32'(cs_n), 32'h1);
        bus_rd(4'h8, v);
        check(v == 32'h8900_0000, "R3 R11 control readback", v, 32'h8900_0000);

        // Directed transfers
        do_tx(32'hA5C3_0000, 0, 1'b0);
        do_tx(32'h1234_5678, 3, 1'b1);
        do_tx(32'h1234_5678, 3, 1'b0);
        do_rx(32'h9ABC_DEF0, 3, 1'b0);
        do_rx(32'h3C00_0000, 0, 1'b1);

        // R9 data write while busy is dropped
        setup(3, 1'b1, 1'b1);
        clear_mon();
        bus_wr(4'hC, 32'hCAFE_F00D);
        bus_wr(4'hC, 32'hFFFF_FFFF);
        wait_ready();
        check(mosi_cap == 32'hCAFE_F00D, "R9 busy write ignored", mosi_cap, 32'hCAFE_F00D);

        // R9 data read while busy neither launches nor changes data
        clear_mon();
        slv_word = 32'h5566_7788; slv_idx = 0;
        bus_rd(4'hC, v);
        check(v == prev_cap, "R9 R7 launching read data", v, prev_cap);
        bus_rd(4'hC, v);
        check(v == prev_cap, "R9 busy read returns old capture", v, prev_cap);
        wait_ready();
        repeat (HALF*4) @(negedge clk);
        check(rises == 32, "R9 no extra transfer", rises, 32);
        prev_cap = 32'h5566_7788;

        // Random mix
        for (int i = 0; i < 40; i++) begin
            int code;
            bit be;
            logic [31:0] w;
            code = int'($urandom % 4);
            be   = 1'($urandom);
            w    = $urandom;
            if ($urandom % 2) do_tx(w, code, be);
            else              do_rx(w, code, be);
        end
        do_rx(32'h0, 0, 1'b1);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule